// File: doc/BRIEF.md
# Microprogram Sequencer

This block sequences a microprogrammed control unit. A control address register (CAR) points into an on-chip control store of 64 sixteen-bit words. The addressed word is first latched into a control buffer register. On the following clock that buffer either drives the control lines or steers the choice of the next microaddress. Every microinstruction therefore takes two clocks: a fetch clock and an execute clock.

Bit 15 of each word selects its format. A control word puts its lower fifteen bits on the control lines and then moves on to the next sequential address. A branch word holds the control lines low. It carries a three-bit condition that tests the ALU flags, plus a six-bit target address. One condition code instead jumps to a routine chosen from the instruction opcode. The store is filled at build time with a small fetch-and-dispatch microprogram.

Top module: `microseq_top`

## Requirements
- R1: While `rst` is high, `uaddr` is 0 (the entry of the fetch routine) and `ctrl_lines` is 0.
- R2: A microinstruction takes two clocks. `uaddr` and `ctrl_lines` change only on the execute clock and hold their values across the fetch clock that follows.
- R3: When bit 15 of the buffered word is 0, `ctrl_lines` takes bits [14:0] of that word, and the next `uaddr` is the current one plus 1.
- R4: When bit 15 of the buffered word is 1 (branch format), `ctrl_lines` is 0 for that microinstruction.
- R5: A branch word's condition sits in bits [14:12]. The codes are 0 always, 1 Z, 2 C, 3 N, 4 not Z, 5 not C, 6 not N, 7 opcode dispatch. The flags are `alu_flags[0]`=Z, `alu_flags[1]`=C and `alu_flags[2]`=N. When the condition holds, the next `uaddr` is bits [5:0] of the word.
- R6: When a branch condition (codes 0 to 6) does not hold, the next `uaddr` is the current one plus 1.
- R7: Code 7 loads `uaddr` with `{opcode, 2'b00}`, so each opcode owns four words.
- R8: The stored program is laid out as follows.
  - Words 0 and 1 are control words `0x0001` and `0x0002`. Word 2 dispatches on the opcode, and word 3 is zero.
  - Every opcode k from 1 to 15 starts its routine with control word `k*256+0x10` at address 4k.
  - For k from 1 to 7, word 4k+1 branches on condition code k-1 to address 4k+3. Words 4k+2 and 4k+3 branch always to 0.
  - For k from 8 to 15, words 4k+1 and 4k+2 are control words `k*256+0x20` and `k*256+0x40`. Word 4k+3 branches always to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_flags | input | 3 | Z, C, N flags (bit 0, 1, 2), sampled on the execute clock |
| opcode | input | 4 | Instruction opcode, sampled by the dispatch word |
| ctrl_lines | output | 15 | Registered control lines |
| uaddr | output | 6 | Current microaddress (the CAR) |

## Verification
After reset is released, the first execute clock is the second rising edge. From then on, a new result is due every two edges. The new `uaddr` and `ctrl_lines` of a microinstruction both appear after that microinstruction's execute edge. The bench advances two rising edges and samples on the falling edge that follows. It holds `opcode` and the flags steady through each whole instruction, so the dispatch and condition words see known values. A separate check samples again one edge later, in the middle of the fetch clock, to confirm the outputs have held.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  localparam int UA_W  = 6;
  localparam int UW_W  = 16;
  localparam int OP_W  = 4;
  localparam int CND_W = 3;
  localparam int CL_W  = UW_W - 1;
  localparam int PAD_W = UW_W - 1 - CND_W - UA_W;

  typedef enum logic [CND_W-1:0] {
    C_ALWAYS = 3'd0, C_Z = 3'd1, C_C = 3'd2, C_N = 3'd3,
    C_NZ = 3'd4, C_NC = 3'd5, C_NN = 3'd6, C_MAP = 3'd7
  } cond_e;

  function automatic logic [UW_W-1:0] ctl_word(input int lines);
    return {1'b0, CL_W'(lines)};
  endfunction

  function automatic logic [UW_W-1:0] br_word(input cond_e c, input int tgt);
    return {1'b1, c, {PAD_W{1'b0}}, UA_W'(tgt)};
  endfunction

  // Build-time microprogram: fetch at 0, four words per opcode routine.
  function automatic logic [UW_W-1:0] ucode_word(input int a);
    int k;
    int s;
    k = a / 4;
    s = a % 4;
    if (k == 0) begin
      case (s)
        0:       return ctl_word(16'h0001);
        1:       return ctl_word(16'h0002);
        2:       return br_word(C_MAP, 0);
        default: return ctl_word(0);
      endcase
    end
    case (s)
      0:       return ctl_word((k << 8) | 16'h10);
      1:       return (k <= 7) ? br_word(cond_e'(CND_W'(k - 1)), a + 2)
                               : ctl_word((k << 8) | 16'h20);
      2:       return (k <= 7) ? br_word(C_ALWAYS, 0)
                               : ctl_word((k << 8) | 16'h40);
      default: return br_word(C_ALWAYS, 0);
    endcase
  endfunction
endpackage

// File: rtl/microseq_store.sv
module microseq_store
  import microseq_pkg::*;
#(
  parameter int AW = UA_W,
  parameter int DW = UW_W
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(ucode_word(i));
  end

  // Registered read port: this register is the control buffer.
  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[addr];
  end
endmodule

// File: rtl/microseq_nextaddr.sv
module microseq_nextaddr
  import microseq_pkg::*;
#(
  parameter int AW  = UA_W,
  parameter int DW  = UW_W,
  parameter int OPW = OP_W
) (
  input  logic [DW-1:0]  word,
  input  logic [AW-1:0]  car,
  input  logic [2:0]     flags,
  input  logic [OPW-1:0] opcode,
  output logic [AW-1:0]  next_addr
);
  localparam int SHIFT = AW - OPW;

  cond_e cond;
  logic  hit;
  logic  fz, fc, fn;

  assign fz = flags[0];
  assign fc = flags[1];
  assign fn = flags[2];

  always_comb begin
    cond = cond_e'(word[DW-2 -: CND_W]);
    case (cond)
      C_ALWAYS: hit = 1'b1;
      C_Z:      hit = fz;
      C_C:      hit = fc;
      C_N:      hit = fn;
      C_NZ:     hit = ~fz;
      C_NC:     hit = ~fc;
      C_NN:     hit = ~fn;
      default:  hit = 1'b0;
    endcase
    next_addr = car + AW'(1);
    if (word[DW-1]) begin
      if (cond == C_MAP)  next_addr = AW'(opcode) << SHIFT;
      else if (hit)       next_addr = word[AW-1:0];
    end
  end
endmodule

// File: rtl/microseq_top.sv
module microseq_top
  import microseq_pkg::*;
#(
  parameter int AW  = UA_W,
  parameter int DW  = UW_W,
  parameter int OPW = OP_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2:0]     alu_flags,
  input  logic [OPW-1:0] opcode,
  output logic [DW-2:0]  ctrl_lines,
  output logic [AW-1:0]  uaddr
);
  localparam int SHIFT = AW - OPW;

  logic          exec_ph;
  logic [DW-1:0] cbr;
  logic [AW-1:0] car_nx;

  microseq_store #(.AW(AW), .DW(DW)) store_i (
    .clk(clk), .rd_en(~exec_ph), .addr(uaddr), .rd_data(cbr)
  );

  microseq_nextaddr #(.AW(AW), .DW(DW), .OPW(OPW)) nxt_i (
    .word(cbr), .car(uaddr), .flags(alu_flags), .opcode(opcode),
    .next_addr(car_nx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      exec_ph    <= 1'b0;
      uaddr      <= '0;
      ctrl_lines <= '0;
    end else begin
      exec_ph <= ~exec_ph;
      if (exec_ph) begin
        uaddr      <= car_nx;
        ctrl_lines <= cbr[DW-1] ? '0 : cbr[DW-2:0];
      end
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !exec_ph |=> ($stable(uaddr) && $stable(ctrl_lines)));

  assert_seq_R3: assert property (@(posedge clk) disable iff (rst)
    (exec_ph && !cbr[DW-1]) |=> (uaddr == $past(uaddr) + AW'(1)));

  assert_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (exec_ph && cbr[DW-1]) |=> (ctrl_lines == '0));

  assert_always_R5: assert property (@(posedge clk) disable iff (rst)
    (exec_ph && cbr[DW-1] && cbr[DW-2 -: CND_W] == C_ALWAYS)
      |=> (uaddr == $past(cbr[AW-1:0])));

  assert_map_R7: assert property (@(posedge clk) disable iff (rst)
    (exec_ph && cbr[DW-1] && cbr[DW-2 -: CND_W] == C_MAP)
      |=> (uaddr == (AW'($past(opcode)) << SHIFT)));
endmodule

// File: tb/microseq_top_tb_top.sv
module microseq_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  alu_flags;
  logic [3:0]  opcode;
  logic [14:0] ctrl_lines;
  logic [5:0]  uaddr;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  microseq_top dut_i (
    .clk(clk), .rst(rst), .alu_flags(alu_flags), .opcode(opcode),
    .ctrl_lines(ctrl_lines), .uaddr(uaddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  // Condition code k-1 against flags Z=bit0, C=bit1, N=bit2
  function automatic bit exp_taken(input int k, input logic [2:0] f);
    case (k - 1)
      0: return 1'b1;
      1: return f[0];
      2: return f[1];
      3: return f[2];
      4: return ~f[0];
      5: return ~f[1];
      default: return ~f[2];
    endcase
  endfunction

  task automatic run_instr(input int k, input logic [2:0] f);
    opcode = 4'(k);
    alu_flags = f;
    step(); check("R3 fetch0 uaddr", uaddr, 1); check("R8 fetch0 ctrl", ctrl_lines, 1);
    step(); check("R3 fetch1 uaddr", uaddr, 2); check("R8 fetch1 ctrl", ctrl_lines, 2);
    step(); check("R7 dispatch uaddr", uaddr, 4*k); check("R4 dispatch ctrl", ctrl_lines, 0);
    if (k == 0) return;
    step(); check("R3 entry uaddr", uaddr, 4*k+1);
    check("R8 entry ctrl", ctrl_lines, k*256 + 'h10);
    if (k <= 7) begin
      step();
      if (exp_taken(k, f)) check("R5 taken uaddr", uaddr, 4*k+3);
      else                 check("R6 not-taken uaddr", uaddr, 4*k+2);
      check("R4 cond ctrl", ctrl_lines, 0);
      step(); check("R5 return uaddr", uaddr, 0); check("R4 return ctrl", ctrl_lines, 0);
    end else begin
      step(); check("R3 seq uaddr", uaddr, 4*k+2); check("R8 seq ctrl", ctrl_lines, k*256 + 'h20);
      step(); check("R3 seq2 uaddr", uaddr, 4*k+3); check("R8 seq2 ctrl", ctrl_lines, k*256 + 'h40);
      step(); check("R5 return uaddr", uaddr, 0); check("R4 return ctrl", ctrl_lines, 0);
    end
  endtask

  task automatic task_reset();
    rst = 1'b1; alu_flags = '0; opcode = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset uaddr", uaddr, 0);
    check("R1 reset ctrl", ctrl_lines, 0);
    rst = 1'b0;
  endtask

  task automatic task_hold();
    opcode = 4'd9; alu_flags = 3'b000;
    step(); check("R2 exec uaddr", uaddr, 1);
    @(posedge clk); @(negedge clk);
    check("R2 mid uaddr", uaddr, 1); check("R2 mid ctrl", ctrl_lines, 1);
    @(posedge clk); @(negedge clk);
    check("R2 next uaddr", uaddr, 2);
    for (int i = 0; i < 5; i++) step();
    check("R2 end uaddr", uaddr, 0);
  endtask

  task automatic task_branches();
    for (int k = 1; k <= 7; k++) begin
      run_instr(k, 3'b000);
      run_instr(k, 3'b111);
    end
    run_instr(2, 3'b110);
    run_instr(3, 3'b101);
    run_instr(6, 3'b011);
  endtask

  task automatic task_long_routines();
    run_instr(8, 3'b010);
    run_instr(15, 3'b101);
    run_instr(12, 3'b000);
  endtask

  task automatic task_nop();
    run_instr(0, 3'b000);
    step(); check("R3 refetch uaddr", uaddr, 1);
    for (int i = 0; i < 2; i++) step();
    check("R7 nop dispatch", uaddr, 0);
  endtask

  initial begin
    task_reset();
    task_hold();
    task_branches();
    task_long_routines();
    task_nop();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule